// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block sends stereo audio over a three-wire serial link: a bit clock, a word-select line and one data line. Each frame holds two 16-bit two's-complement samples. The left sample goes first and the right sample second, each one most-significant bit first. The bit clock is normally made by dividing the system clock with a programmable half-period count. For rates that do not divide evenly, such as the 44.1 kHz family, an external clock-enable pulse can drive the bit clock instead.

Samples arrive as left/right pairs through a valid/ready handshake into a one-pair buffer. At each frame boundary the serializer takes the buffered pair. If the buffer is empty it sends the previous pair again and raises a one-cycle underflow pulse. A static configuration bit chooses which bit-clock transition launches data, so the other transition is the one a receiver samples on.

With 16-bit words the bit clock runs at 32 times the sample rate. For example, 48 kHz needs 1.536 MHz, which is a half-period count of 15 from a 49.152 MHz system clock.

Top module: `stereo_serial_tx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ws` is 0, `sdata` is 0, `underflow` is 0, `s_ready` is 1 and `bclk` equals `cfg_launch_rise`.
- R2: With `cfg_ext_clk` = 0, `bclk` toggles every `cfg_half_div`+1 system-clock cycles.
- R3: With `cfg_ext_clk` = 1, `bclk` toggles once for each cycle in which `ext_bit_tick` is high, and `cfg_half_div` has no effect.
- R4: `ws` and `sdata` change only in the cycle in which `bclk` moves to the launch level. The launch level is low (falling edge) when `cfg_launch_rise` = 0 and high (rising edge) when it is 1. Data is therefore launched on every second `bclk` transition.
- R5: A frame is 32 bit periods. Bit positions 0 to 15 carry the left sample and positions 16 to 31 carry the right sample, each with bit 15 first. Sample values go out unchanged.
- R6: `ws` is low for the left word and high for the right word, and it changes one bit period before each word's first bit. As seen at the sampling edge, `ws` is 1 at positions 15 to 30 and 0 at the others.
- R7: `s_ready` is 1 exactly when the one-pair buffer is empty. An accepted pair makes `s_ready` drop in the next cycle. The pair is consumed when the next frame starts, and `s_ready` rises again in the cycle after that.
- R8: If the buffer is empty when a frame starts, the previous pair is sent again and `underflow` is high for exactly one system-clock cycle. This also happens before the first pair has arrived.
- R9: After reset, `sdata` stays 0 until the first accepted pair has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_div | input | DIV_W | Bit-clock half period minus one, in system-clock cycles |
| cfg_ext_clk | input | 1 | 1: `ext_bit_tick` paces the bit clock instead of the divider |
| cfg_launch_rise | input | 1 | 0: data launched on the falling `bclk` edge; 1: on the rising edge |
| ext_bit_tick | input | 1 | External half-period strobe, one system-clock cycle wide |
| s_valid | input | 1 | A sample pair is offered |
| s_ready | output | 1 | The pair buffer is empty and accepts a pair |
| s_left | input | SAMPLE_W | Left sample, two's complement |
| s_right | input | SAMPLE_W | Right sample, two's complement |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select: 0 left, 1 right |
| sdata | output | 1 | Serial data |
| underflow | output | 1 | One-cycle pulse when a frame starts with no new pair |

## Verification
The assertions assume the three configuration inputs change only while reset is high. They also assume `s_valid` and its data stay steady until the pair is accepted. The bench reconfigures the block only inside a reset window and holds each offered pair until `s_ready` is seen high at a clock edge. The external strobe is never driven faster than one pulse every third cycle, and it is driven only in the external-clock configurations.

// File: rtl/sstx_pkg.sv
`timescale 1ns/1ps
package sstx_pkg;

    // Which bit-clock transition launches data.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } launch_edge_e;

    // Per-cycle bit-clock events from the generator.
    typedef struct packed {
        logic tick;    // bclk toggles at this edge
        logic launch;  // the toggle goes to the launch level
    } bclk_evt_t;

    // Half-period count (minus one) for a given system clock, sample rate and word width.
    function automatic int unsigned half_div_for(int unsigned sys_hz,
                                                 int unsigned fs_hz,
                                                 int unsigned word_w);
        return sys_hz / (4 * word_w * fs_hz) - 1;
    endfunction

    // Channel carried by the slot after 'pos' in a frame of 2*word_w slots.
    function automatic logic next_is_right(int pos, int word_w);
        int nxt;
        nxt = (pos + 1) % (2 * word_w);
        return (nxt >= word_w);
    endfunction

endpackage

// File: rtl/sstx_clkgen.sv
`timescale 1ns/1ps
module sstx_clkgen
    import sstx_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_div,
    input  logic             ext_sel,
    input  logic             ext_tick,
    input  launch_edge_e     edge_sel,
    output logic             bclk,
    output bclk_evt_t        evt
);

    logic [DIV_W-1:0] cnt_q;
    logic             bclk_q;
    logic             int_tick;

    assign int_tick = (cnt_q >= half_div);

    always_comb begin
        evt.tick   = ext_sel ? ext_tick : int_tick;
        evt.launch = evt.tick && (bclk_q != logic'(edge_sel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            bclk_q <= logic'(edge_sel);
        end else begin
            if (ext_sel || int_tick)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
            if (evt.tick)
                bclk_q <= ~bclk_q;
        end
    end

    assign bclk = bclk_q;

    // R2/R3: bclk only moves on a tick.
    p_bclk_still_r2: assert property (@(posedge clk) disable iff (rst)
        !evt.tick |=> $stable(bclk_q));

    // R4: launches fall on every second toggle, never in back-to-back cycles.
    p_launch_spaced_r4: assert property (@(posedge clk) disable iff (rst)
        evt.launch |=> !evt.launch);

endmodule

// File: rtl/sstx_pairbuf.sv
`timescale 1ns/1ps
module sstx_pairbuf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_left,
    input  logic [W-1:0] in_right,
    output logic         in_ready,
    input  logic         take,
    output logic         pair_valid,
    output logic [W-1:0] pair_left,
    output logic [W-1:0] pair_right
);

    logic         full_q;
    logic [W-1:0] left_q;
    logic [W-1:0] right_q;
    logic         accept;

    assign in_ready = !full_q;
    assign accept   = in_valid && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q  <= 1'b0;
            left_q  <= '0;
            right_q <= '0;
        end else if (accept) begin
            full_q  <= 1'b1;
            left_q  <= in_left;
            right_q <= in_right;
        end else if (take) begin
            full_q  <= 1'b0;
        end
    end

    assign pair_valid = full_q;
    assign pair_left  = left_q;
    assign pair_right = right_q;

    // R7: an accepted pair closes the buffer next cycle.
    p_accept_fills_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R7: the serializer consuming the pair reopens it.
    p_take_empties_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> in_ready);

endmodule

// File: rtl/sstx_serializer.sv
`timescale 1ns/1ps
module sstx_serializer
    import sstx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         launch,
    input  logic         pair_valid,
    input  logic [W-1:0] pair_left,
    input  logic [W-1:0] pair_right,
    output logic         take,
    output logic         ws,
    output logic         sdata,
    output logic         underflow
);

    localparam int FRAME = 2 * W;
    localparam int POS_W = $clog2(FRAME);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME - 1);

    logic [POS_W-1:0] pos_q, pos_nxt;
    logic [FRAME-1:0] sr_q, hold_q, load_word;
    logic             ws_q, sdata_q, uf_q, loaded_q;
    logic             frame_start;

    always_comb begin
        frame_start = launch && (pos_q == LAST);
        pos_nxt     = (pos_q == LAST) ? '0 : pos_q + 1'b1;
        load_word   = pair_valid ? {pair_left, pair_right} : hold_q;
        take        = frame_start && pair_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= LAST;
            ws_q     <= 1'b0;
            sdata_q  <= 1'b0;
            sr_q     <= '0;
            hold_q   <= '0;
            uf_q     <= 1'b0;
            loaded_q <= 1'b0;
        end else begin
            uf_q <= frame_start && !pair_valid;
            if (launch) begin
                pos_q <= pos_nxt;
                ws_q  <= next_is_right(int'(pos_nxt), W);
                if (frame_start) begin
                    sdata_q  <= load_word[FRAME-1];
                    sr_q     <= {load_word[FRAME-2:0], 1'b0};
                    hold_q   <= load_word;
                    loaded_q <= loaded_q || pair_valid;
                end else begin
                    sdata_q <= sr_q[FRAME-1];
                    sr_q    <= {sr_q[FRAME-2:0], 1'b0};
                end
            end
        end
    end

    assign ws        = ws_q;
    assign sdata     = sdata_q;
    assign underflow = uf_q;

    // R4: word select holds between launches from the generator.
    p_ws_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !launch |=> $stable(ws_q));

    // R8: underflow is a single-cycle pulse.
    p_uf_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        uf_q |=> !uf_q);

    // R9: the line stays low until a real pair has been loaded.
    p_zero_before_load_r9: assert property (@(posedge clk) disable iff (rst)
        !loaded_q |-> !sdata_q);

endmodule

// File: rtl/stereo_serial_tx.sv
`timescale 1ns/1ps
module stereo_serial_tx
    import sstx_pkg::*;
#(
    parameter int DIV_W    = 10,
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_W-1:0]    cfg_half_div,
    input  logic                cfg_ext_clk,
    input  logic                cfg_launch_rise,
    input  logic                ext_bit_tick,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                bclk,
    output logic                ws,
    output logic                sdata,
    output logic                underflow
);

    bclk_evt_t           evt;
    logic                take;
    logic                pair_valid;
    logic [SAMPLE_W-1:0] pair_left, pair_right;
    launch_edge_e        edge_sel;

    assign edge_sel = launch_edge_e'(cfg_launch_rise);

    sstx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .half_div (cfg_half_div),
        .ext_sel  (cfg_ext_clk),
        .ext_tick (ext_bit_tick),
        .edge_sel (edge_sel),
        .bclk     (bclk),
        .evt      (evt)
    );

    sstx_pairbuf #(.W(SAMPLE_W)) u_pairbuf (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (s_valid),
        .in_left    (s_left),
        .in_right   (s_right),
        .in_ready   (s_ready),
        .take       (take),
        .pair_valid (pair_valid),
        .pair_left  (pair_left),
        .pair_right (pair_right)
    );

    sstx_serializer #(.W(SAMPLE_W)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .launch     (evt.launch),
        .pair_valid (pair_valid),
        .pair_left  (pair_left),
        .pair_right (pair_right),
        .take       (take),
        .ws         (ws),
        .sdata      (sdata),
        .underflow  (underflow)
    );

    // R4/R6: a word-select change coincides with bclk reaching the launch level.
    p_ws_on_launch_edge_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws) |-> (!$stable(bclk) && (bclk == cfg_launch_rise)));

    // R4: serial data changes only together with bclk.
    p_data_with_bclk_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata) |-> !$stable(bclk));

endmodule

// File: tb/stereo_serial_tx_test.sv
`timescale 1ns/1ps
module stereo_serial_tx_test;

    localparam int DW = 10;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] cfg_half_div = '0;
    logic          cfg_ext_clk = 1'b0;
    logic          cfg_launch_rise = 1'b0;
    logic          ext_bit_tick = 1'b0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [SW-1:0] s_left = '0, s_right = '0;
    logic          bclk, ws, sdata, underflow;

    always #2.5 clk = ~clk;

    stereo_serial_tx #(.DIV_W(DW), .SAMPLE_W(SW)) uut (
        .clk(clk), .rst(rst), .cfg_half_div(cfg_half_div), .cfg_ext_clk(cfg_ext_clk),
        .cfg_launch_rise(cfg_launch_rise), .ext_bit_tick(ext_bit_tick),
        .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
        .bclk(bclk), .ws(ws), .sdata(sdata), .underflow(underflow)
    );

    int checks = 0, errors = 0;
    int rx_checks = 0, rx_errors = 0;
    int exp_half = 1;
    logic ext_on = 1'b0;

    // External strobe: one pulse every third cycle while enabled.
    initial begin
        int ec;
        ec = 0;
        forever begin
            @(negedge clk);
            if (ext_on) begin
                ec = ec + 1;
                ext_bit_tick = (ec % 3 == 0);
            end else begin
                ec = 0;
                ext_bit_tick = 1'b0;
            end
        end
    end

    // Receiver model: decodes frames and checks timing at the ports.
    logic [SW-1:0] fl [0:31];
    logic [SW-1:0] fr [0:31];
    int nfr, nsamp, nstart, uf_cnt, uf_snap, since;
    logic have_chg, started, prev_bclk, prev_ws, prev_sd;
    logic [SW-1:0] wb, cur_l;

    always @(negedge clk) begin
        if (rst) begin
            nfr = 0; nsamp = 0; nstart = 0; uf_cnt = 0; uf_snap = 0; since = 0;
            have_chg = 1'b0; started = 1'b0; wb = '0; cur_l = '0;
        end else begin
            int p;
            logic changed, exp_ws;
            changed = (bclk != prev_bclk);
            if (underflow) uf_cnt = uf_cnt + 1;
            if ((ws != prev_ws) || (sdata != prev_sd)) begin
                rx_checks = rx_checks + 1;
                if (!(changed && bclk == cfg_launch_rise)) begin
                    rx_errors = rx_errors + 1;
                    $display("FAIL R4: data/ws moved with bclk=%0b changed=%0b, expected bclk=%0b on a transition",
                             bclk, changed, cfg_launch_rise);
                end
            end
            if (changed) begin
                if (have_chg) begin
                    rx_checks = rx_checks + 1;
                    if (since + 1 != exp_half) begin
                        rx_errors = rx_errors + 1;
                        $display("FAIL %s: bclk half period %0d, expected %0d",
                                 cfg_ext_clk ? "R3" : "R2", since + 1, exp_half);
                    end
                end
                have_chg = 1'b1;
                since = 0;
                if (bclk == cfg_launch_rise) begin
                    started = 1'b1;
                end else if (started) begin
                    p = nsamp % 32;
                    exp_ws = (p >= 15 && p <= 30);
                    rx_checks = rx_checks + 1;
                    if (ws != exp_ws) begin
                        rx_errors = rx_errors + 1;
                        $display("FAIL R6: ws at position %0d is %0b, expected %0b", p, ws, exp_ws);
                    end
                    wb = {wb[SW-2:0], sdata};
                    if (p == 0) begin
                        nstart = nstart + 1;
                        uf_snap = uf_cnt;
                    end
                    if (p == 15) cur_l = wb;
                    if (p == 31 && nfr < 32) begin
                        fl[nfr] = cur_l;
                        fr[nfr] = wb;
                        nfr = nfr + 1;
                    end
                    nsamp = nsamp + 1;
                end
            end else begin
                since = since + 1;
            end
        end
        prev_bclk = bclk;
        prev_ws = ws;
        prev_sd = sdata;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [SW-1:0] l, input logic [SW-1:0] r);
        @(negedge clk);
        s_valid = 1'b1; s_left = l; s_right = r;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        check(s_ready == 1'b0, "R7 ready drops after accept", s_ready, 0);
    endtask

    task automatic run_cfg(input logic lr, input logic ex, input int div,
                           input logic [SW-1:0] al, input logic [SW-1:0] ar,
                           input logic [SW-1:0] bl, input logic [SW-1:0] br);
        int fc, k;
        rst = 1'b1;
        ext_on = 1'b0;
        cfg_launch_rise = lr;
        cfg_ext_clk = ex;
        cfg_half_div = ex ? DW'(0) : DW'(div);
        exp_half = ex ? 3 : div + 1;
        fc = 64 * exp_half;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ws == 1'b0 && sdata == 1'b0 && underflow == 1'b0, "R1 outputs idle",
              {ws, sdata, underflow}, 0);
        check(s_ready == 1'b1, "R1 ready", s_ready, 1);
        check(bclk == lr, "R1 bclk level", bclk, lr);
        rst = 1'b0;
        ext_on = ex;
        repeat (2 * fc) @(negedge clk);
        check(s_ready == 1'b1, "R7 empty buffer ready", s_ready, 1);
        push(al, ar);
        push(bl, br);
        repeat (5 * fc) @(negedge clk);

        check(nfr >= 5, "R5 frames received", nfr, 5);
        k = 0;
        while (k < nfr && fl[k] == '0 && fr[k] == '0) k = k + 1;
        // R9: silent frames before the first pair
        check(k >= 1, "R9 zero frames before load", k, 1);
        check(k + 1 < nfr, "R5 loaded frames seen", k + 1, nfr);
        if (k + 1 < nfr) begin
            check(fl[k] == al, "R5 first left word", fl[k], al);
            check(fr[k] == ar, "R5 first right word", fr[k], ar);
            for (int j = k + 1; j < nfr; j++) begin
                check(fl[j] == bl, "R8 repeated left word", fl[j], bl);
                check(fr[j] == br, "R8 repeated right word", fr[j], br);
            end
        end
        check(uf_snap == nstart - 2, "R8 underflow count", uf_snap, nstart - 2);
        ext_on = 1'b0;
    endtask

    initial begin
        run_cfg(1'b0, 1'b0, 0, 16'h8001, 16'h7FFE, 16'hFFFF, 16'h0001);
        run_cfg(1'b1, 1'b0, 0, 16'h1234, 16'hEDCB, 16'h8000, 16'h7FFF);
        run_cfg(1'b0, 1'b0, 2, 16'hA5C3, 16'h5A3C, 16'h0F0F, 16'hF0F0);
        run_cfg(1'b1, 1'b0, 3, 16'h0001, 16'h8000, 16'hC001, 16'h3FFE);
        // R3: external strobe paces bclk; divider left at 0 has no effect
        run_cfg(1'b0, 1'b1, 0, 16'h4321, 16'hBCDE, 16'h00FF, 16'hFF00);
        run_cfg(1'b1, 1'b1, 0, 16'h7001, 16'h9FFE, 16'h2468, 16'hDB97);
        $display("Result: errors=%0d of %0d checks", errors + rx_errors, checks + rx_checks);
        $finish;
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            $display("FAIL watchdog: run did not finish, cycles %0d expected below %0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors + rx_errors + 1, checks + rx_checks + 1);
            $finish;
        end
    end

endmodule